// File: doc/BRIEF.md
# Channel Poll Interrupt Sequencer

This block steps an I/O channel through the handover of a device's pending interrupt status to the CPU. A three-bit state register holds the unit-select-in, poll and interrupt-end flags. When a device signals that status is waiting, the sequencer captures the status byte. It then asks a shared common channel for service and waits for the grant. After the grant it selects the unit and waits for selection to finish. It then raises an interrupt-routine request to the CPU and holds it until the CPU acknowledges the status. On that acknowledgement the channel replies with a one-cycle command-out and drops back to idle.

Every output is a flop. Each handshake input counts only during the step that waits for it. The captured status stays on its output until the next capture. The two codes of the three-bit state that are not defined are decoded, flagged and sent to idle.

Top module: `poll_int_seq`

## Requirements
- R1: After reset, seq_state is 3'b000 and cc_req, sel_out, int_req, cmd_out, illegal_code and stacked_status are all 0.
- R2: seq_state is {unit-select-in, poll, interrupt-end} in bits [2], [1], [0]. In idle (000), a high dev_status_avail at a clock edge moves the state to 010. Otherwise the state stays 000.
- R3: From 010 the state moves to 011 at the next edge. At that same edge stacked_status loads dev_status.
- R4: In 011, cc_req is 1 and the state holds until cc_grant is high at an edge, which moves it to 111.
- R5: In 111, sel_out is 1 and the state holds until sel_done is high at an edge, which moves it to 101.
- R6: In 101, int_req is 1, and the state moves to 001 at the next edge whatever the inputs are.
- R7: In 001, int_req stays 1 until cpu_ack is high at an edge. That edge returns the state to 000 and makes cmd_out 1 for exactly one cycle.
- R8: cc_grant, sel_done and cpu_ack have no effect on the state or outputs outside the step that waits for each of them.
- R9: stacked_status changes only at the edge that leaves state 010. It holds its value through the rest of the sequence and in idle.
- R10: The codes 100 and 110 are never held. If either is decoded, illegal_code pulses and the state returns to 000. In legal operation illegal_code stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_status_avail | input | 1 | Device has interrupt status waiting |
| dev_status | input | STAT_W | Device status byte |
| cc_grant | input | 1 | Common channel honours the request |
| sel_done | input | 1 | Unit selection finished, status taken |
| cpu_ack | input | 1 | CPU has received the polling status |
| cc_req | output | 1 | Request to the common channel |
| sel_out | output | 1 | Select-out to the device |
| int_req | output | 1 | Request for the interrupt routine |
| cmd_out | output | 1 | One-cycle command-out reply |
| illegal_code | output | 1 | Undefined state code decoded |
| seq_state | output | 3 | {unit-select-in, poll, interrupt-end} |
| stacked_status | output | STAT_W | Captured device status |

## Verification
The assertions assume that all inputs are synchronous to clk and stable around each edge. They do not assume that the handshake inputs arrive in order, because the design has to ignore early or stray strobes. The stimulus drives inputs one time unit after each rising edge. It deliberately raises grants, selection-done and acknowledgements in the wrong steps so that the hold properties are exercised.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam logic [2:0] ST_IDLE    = 3'b000;
  localparam logic [2:0] ST_WAIT    = 3'b010;
  localparam logic [2:0] ST_STACKED = 3'b011;
  localparam logic [2:0] ST_SELECT  = 3'b111;
  localparam logic [2:0] ST_TAKEN   = 3'b101;
  localparam logic [2:0] ST_ROUTINE = 3'b001;
endpackage

// File: rtl/pis_fsm.sv
module pis_fsm
  import pis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       avail,
  input  logic       grant,
  input  logic       sel_done,
  input  logic       ack,
  output logic [2:0] state_q,
  output logic [2:0] state_d,
  output logic       illegal_d
);
  always_comb begin
    state_d   = state_q;
    illegal_d = 1'b0;
    case (state_q)
      ST_IDLE:    if (avail)    state_d = ST_WAIT;
      ST_WAIT:                  state_d = ST_STACKED;
      ST_STACKED: if (grant)    state_d = ST_SELECT;
      ST_SELECT:  if (sel_done) state_d = ST_TAKEN;
      ST_TAKEN:                 state_d = ST_ROUTINE;
      ST_ROUTINE: if (ack)      state_d = ST_IDLE;
      default: begin
        state_d   = ST_IDLE;
        illegal_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R2: idle holds without a status-available strobe
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !avail) |=> state_q == ST_IDLE);
  // R4: request step waits for the grant
  a_r4_wait_grant: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STACKED && !grant) |=> state_q == ST_STACKED);
  // R5: selection step waits for completion
  a_r5_wait_sel: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SELECT && !sel_done) |=> state_q == ST_SELECT);
  // R6: status-taken step lasts one cycle
  a_r6_taken_once: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_TAKEN |=> state_q == ST_ROUTINE);
  // R10: undefined codes are never held
  a_r10_no_illegal: assert property (@(posedge clk) disable iff (rst)
    state_q != 3'b100 && state_q != 3'b110);
endmodule

// File: rtl/pis_stack.sv
module pis_stack
  import pis_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        state_q,
  input  logic [STAT_W-1:0] status_in,
  output logic [STAT_W-1:0] status_q
);
  logic capture;
  assign capture = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst)          status_q <= '0;
    else if (capture) status_q <= status_in;
  end

  // R9: held except at the capture edge
  a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_WAIT) |=> $stable(status_q));
endmodule

// File: rtl/pis_out.sv
module pis_out
  import pis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] state_q,
  input  logic [2:0] state_d,
  input  logic       illegal_d,
  input  logic       ack,
  output logic       cc_req,
  output logic       sel_out,
  output logic       int_req,
  output logic       cmd_out,
  output logic       illegal
);
  logic reply_d;
  assign reply_d = (state_q == ST_ROUTINE) && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_req  <= 1'b0;
      sel_out <= 1'b0;
      int_req <= 1'b0;
      cmd_out <= 1'b0;
      illegal <= 1'b0;
    end else begin
      cc_req  <= (state_d == ST_STACKED);
      sel_out <= (state_d == ST_SELECT);
      int_req <= (state_d == ST_TAKEN) || (state_d == ST_ROUTINE);
      cmd_out <= reply_d;
      illegal <= illegal_d;
    end
  end

  // R7: acknowledgement in the routine step yields command-out
  a_r7_reply: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ROUTINE && ack) |=> cmd_out && state_q == ST_IDLE);
  // R7: command-out lasts a single cycle
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_out |=> !cmd_out);
  // R4: request visible only while waiting for the common channel
  a_r4_req_match: assert property (@(posedge clk) disable iff (rst)
    cc_req == (state_q == ST_STACKED));
endmodule

// File: rtl/poll_int_seq.sv
module poll_int_seq #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_status_avail,
  input  logic [STAT_W-1:0] dev_status,
  input  logic              cc_grant,
  input  logic              sel_done,
  input  logic              cpu_ack,
  output logic              cc_req,
  output logic              sel_out,
  output logic              int_req,
  output logic              cmd_out,
  output logic              illegal_code,
  output logic [2:0]        seq_state,
  output logic [STAT_W-1:0] stacked_status
);
  logic [2:0] st_q;
  logic [2:0] st_d;
  logic       ill_d;

  pis_fsm i_fsm (
    .clk(clk), .rst(rst), .avail(dev_status_avail), .grant(cc_grant),
    .sel_done(sel_done), .ack(cpu_ack),
    .state_q(st_q), .state_d(st_d), .illegal_d(ill_d)
  );

  pis_stack #(.STAT_W(STAT_W)) i_stack (
    .clk(clk), .rst(rst), .state_q(st_q),
    .status_in(dev_status), .status_q(stacked_status)
  );

  pis_out i_out (
    .clk(clk), .rst(rst), .state_q(st_q), .state_d(st_d),
    .illegal_d(ill_d), .ack(cpu_ack),
    .cc_req(cc_req), .sel_out(sel_out), .int_req(int_req),
    .cmd_out(cmd_out), .illegal(illegal_code)
  );

  assign seq_state = st_q;
endmodule

// File: tb/test_poll_int_seq.sv
`timescale 1ns/1ps
module test_poll_int_seq;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic avail = 1'b0, grant = 1'b0, seld = 1'b0, ack = 1'b0;
  logic [W-1:0] stat = '0;
  logic cc_req, sel_out, int_req, cmd_out, illegal_code;
  logic [2:0] seq_state;
  logic [W-1:0] stacked_status;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  poll_int_seq #(.STAT_W(W)) i_poll_int_seq (
    .clk(clk), .rst(rst), .dev_status_avail(avail), .dev_status(stat),
    .cc_grant(grant), .sel_done(seld), .cpu_ack(ack),
    .cc_req(cc_req), .sel_out(sel_out), .int_req(int_req),
    .cmd_out(cmd_out), .illegal_code(illegal_code),
    .seq_state(seq_state), .stacked_status(stacked_status)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs packed {cc_req,sel_out,int_req,cmd_out,illegal}
  function automatic logic [4:0] outs();
    return {cc_req, sel_out, int_req, cmd_out, illegal_code};
  endfunction

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R1 state", seq_state, 3'b000);
    chk("R1 outputs", outs(), 5'b0);
    chk("R1 status", stacked_status, 8'h00);
  endtask

  task automatic t_full(input logic [W-1:0] s);
    tick(); chk("R2 idle hold", seq_state, 3'b000);
    avail = 1'b1; stat = s; tick(); avail = 1'b0;
    chk("R2 to 010", seq_state, 3'b010);
    tick(); stat = ~s;
    chk("R3 to 011", seq_state, 3'b011);
    chk("R3 capture", stacked_status, s);
    chk("R4 cc_req", outs(), 5'b10000);
    tick(); chk("R4 hold", seq_state, 3'b011);
    grant = 1'b1; tick(); grant = 1'b0;
    chk("R4 to 111", seq_state, 3'b111);
    chk("R5 sel_out", outs(), 5'b01000);
    tick(); chk("R5 hold", seq_state, 3'b111);
    seld = 1'b1; tick(); seld = 1'b0;
    chk("R5 to 101", seq_state, 3'b101);
    chk("R6 int_req", outs(), 5'b00100);
    tick(); chk("R6 to 001", seq_state, 3'b001);
    tick(); chk("R7 int_req held", outs(), 5'b00100);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R7 to idle", seq_state, 3'b000);
    chk("R7 cmd_out", outs(), 5'b00010);
    tick(); chk("R7 one pulse", outs(), 5'b0);
    chk("R9 status held", stacked_status, s);
    chk("R10 no illegal", illegal_code, 1'b0);
  endtask

  task automatic t_stray();
    grant = 1'b1; seld = 1'b1; ack = 1'b1; tick();
    chk("R8 idle stray", seq_state, 3'b000);
    chk("R8 idle outs", outs(), 5'b0);
    grant = 1'b0; seld = 1'b0; ack = 1'b0;
    avail = 1'b1; stat = 8'h3C; tick(); avail = 1'b0;
    grant = 1'b1; ack = 1'b1; tick();
    chk("R8 010 stray", seq_state, 3'b011);
    chk("R9 capture 3C", stacked_status, 8'h3C);
    grant = 1'b0; seld = 1'b1; tick();
    chk("R8 011 stray", seq_state, 3'b011);
    seld = 1'b0; grant = 1'b1; tick(); grant = 1'b1;
    tick(); chk("R8 111 stray", seq_state, 3'b111);
    grant = 1'b0; ack = 1'b0; seld = 1'b1; tick(); seld = 1'b0;
    tick(); seld = 1'b1; tick(); seld = 1'b0;
    chk("R8 001 stray", seq_state, 3'b001);
    chk("R8 001 outs", outs(), 5'b00100);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R7 reply", cmd_out, 1'b1);
    stat = 8'hFF; tick(); tick();
    chk("R9 idle hold", stacked_status, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_full(8'hA5);
    t_full(8'h5A);
    t_stray();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule